// File: doc/BRIEF.md
# Sticky fault interrupt aggregator

This block gathers one-cycle event pulses from a set of on-chip fault and event sources and holds each one in a sticky flag bit. A flag stays set until software clears it by writing a one to its position. An active-low interrupt line is asserted while any flag is set. A subset of the flags also asserts an active-low reset request. Another block turns that request into a timed reset pulse.

Software reaches the block through a small word-wide register port with one address, one write strobe and a combinational read path. One address holds the flags. A second holds a force-interrupt bit and a bit that lets watchdog violations request a reset. A read-only status word mirrors the live levels of both output pins.

Each source is assigned a reset route by a parameter mask. The watchdog is the only source whose reset route can be changed at run time. The default flag order is: self-test 0, regulator 1, thermal 2, enable readback 3, uncorrectable memory error 4, watchdog 5, oscillator 6, packet-error check 7, alarm 8, pin readback 9, runtime CRC 10.

Top module: `fault_irq_agg`

## Requirements
- R1: A pulse on `fault_evt[i]` sets flag i at the next rising clock edge, and the flag stays set until cleared. Flags are read at address 0, with bit i holding flag i.
- R2: A write to address 0 clears every flag whose data bit is 1. Data bits that are 0 leave their flags unchanged.
- R3: If an event and a clear hit the same flag in the same cycle, the flag is set after the edge.
- R4: `irq_n` is low exactly when at least one flag is set or the force bit is 1. Both outputs follow the flags with no added cycle.
- R5: `rst_req_n` is low whenever any of flags 0 to 4 (self-test, regulator, thermal, enable readback, memory error) is set.
- R6: Flag 5 (watchdog) pulls `rst_req_n` low only while control bit 1 at address 1 is 1. Otherwise it raises the interrupt alone.
- R7: Flags 6 to 10 (oscillator, packet-error check, alarm, pin readback, CRC) never affect `rst_req_n`.
- R8: Control bit 0 at address 1 forces `irq_n` low whatever the flags hold. Clearing the bit hands `irq_n` back to the flags. Both control bits read back as written.
- R9: Address 2 reads `irq_n` in bit 0 and `rst_req_n` in bit 1. Writes to address 2 change no state.
- R10: After reset all flags and control bits are 0 and both outputs are high. Unused bits, and every bit at address 3, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_evt | input | NUM_FLAGS | One-cycle event pulses, one per source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for read and write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for `reg_addr` |
| irq_n | output | 1 | Active-low interrupt |
| rst_req_n | output | 1 | Active-low reset request |

## Verification
The bench builds the block with its defaults: 11 flags, a 16-bit data word, a 2-bit address, the watchdog at index 5 and the reset mask on flags 0 to 4. These values let random stimulus reach every address, including the unused fourth one. They also let every flag meet every write pattern, so set-versus-clear collisions and writes to the read-only status word occur. Because the reset mask covers exactly five sources, each of the three routing classes (reset-routed, watchdog, interrupt-only) can be driven on its own as well as together with the others.

// File: rtl/fault_irq_pkg.sv
package fault_irq_pkg;
   localparam int unsigned FLT_BIST   = 0;
   localparam int unsigned FLT_REG    = 1;
   localparam int unsigned FLT_THERM  = 2;
   localparam int unsigned FLT_ENRB   = 3;
   localparam int unsigned FLT_MEMERR = 4;
   localparam int unsigned FLT_WDOG   = 5;
   localparam int unsigned FLT_OSC    = 6;
   localparam int unsigned FLT_PEC    = 7;
   localparam int unsigned FLT_ALARM  = 8;
   localparam int unsigned FLT_PINRB  = 9;
   localparam int unsigned FLT_CRC    = 10;
   localparam int unsigned FLT_COUNT  = 11;

   localparam int unsigned ADR_FLAGS = 0;
   localparam int unsigned ADR_CTRL  = 1;
   localparam int unsigned ADR_STAT  = 2;

   localparam int unsigned CTL_FORCE = 0;
   localparam int unsigned CTL_WDRST = 1;
   localparam int unsigned STA_IRQ   = 0;
   localparam int unsigned STA_RST   = 1;

   typedef struct packed {
      logic wdog_rst_en;
      logic force_irq;
   } ctrl_t;
endpackage

// File: rtl/fault_flag_bank.sv
module fault_flag_bank #(
   parameter int unsigned N = 11
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] flag_o
);
   for (genvar i = 0; i < N; i++) begin : g_cell
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        flag_o[i] <= 1'b0;
         else if (set_i[i]) flag_o[i] <= 1'b1;
         else if (clr_i[i]) flag_o[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/fault_route.sv
module fault_route #(
   parameter int unsigned N       = 11,
   parameter logic [N-1:0] RST_MASK = '0,
   parameter int unsigned WD_IDX  = 5
) (
   input  logic [N-1:0] flag_i,
   input  logic         force_irq_i,
   input  logic         wdog_rst_en_i,
   output logic         irq_n_o,
   output logic         rst_req_n_o
);
   logic [N-1:0] rst_hit;

   for (genvar i = 0; i < N; i++) begin : g_route
      if (i == WD_IDX) begin : g_wdog
         assign rst_hit[i] = flag_i[i] & (RST_MASK[i] | wdog_rst_en_i);
      end else if (RST_MASK[i]) begin : g_rst
         assign rst_hit[i] = flag_i[i];
      end else begin : g_irq_only
         assign rst_hit[i] = 1'b0;
      end
   end

   assign irq_n_o     = ~((|flag_i) | force_irq_i);
   assign rst_req_n_o = ~(|rst_hit);
endmodule

// File: rtl/fault_regif.sv
module fault_regif
   import fault_irq_pkg::*;
#(
   parameter int unsigned N      = 11,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [N-1:0]      flag_i,
   input  logic              irq_n_i,
   input  logic              rst_req_n_i,
   output logic [N-1:0]      clr_o,
   output ctrl_t             ctrl_o,
   output logic [DATA_W-1:0] rdata_o
);
   localparam logic [ADDR_W-1:0] A_FLAGS = ADDR_W'(ADR_FLAGS);
   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(ADR_CTRL);
   localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(ADR_STAT);

   logic wr_flags, wr_ctrl;
   assign wr_flags = wr_i && (addr_i == A_FLAGS);
   assign wr_ctrl  = wr_i && (addr_i == A_CTRL);
   assign clr_o    = wr_flags ? wdata_i[N-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_o <= '0;
      end else if (wr_ctrl) begin
         ctrl_o.force_irq   <= wdata_i[CTL_FORCE];
         ctrl_o.wdog_rst_en <= wdata_i[CTL_WDRST];
      end
   end

   always_comb begin
      rdata_o = '0;
      unique case (addr_i)
         A_FLAGS: rdata_o[N-1:0] = flag_i;
         A_CTRL: begin
            rdata_o[CTL_FORCE] = ctrl_o.force_irq;
            rdata_o[CTL_WDRST] = ctrl_o.wdog_rst_en;
         end
         A_STAT: begin
            rdata_o[STA_IRQ] = irq_n_i;
            rdata_o[STA_RST] = rst_req_n_i;
         end
         default: rdata_o = '0;
      endcase
   end

   if (N < DATA_W) begin : g_spare
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^wdata_i[DATA_W-1:N];
   end
endmodule

// File: rtl/fault_irq_agg.sv
module fault_irq_agg
   import fault_irq_pkg::*;
#(
   parameter int unsigned NUM_FLAGS = FLT_COUNT,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned ADDR_W    = 2,
   parameter int unsigned WDOG_IDX  = FLT_WDOG,
   parameter logic [NUM_FLAGS-1:0] RST_ROUTE = NUM_FLAGS'(11'b000_0001_1111)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_FLAGS-1:0] fault_evt,
   input  logic                 reg_wr,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [DATA_W-1:0]    reg_wdata,
   output logic [DATA_W-1:0]    reg_rdata,
   output logic                 irq_n,
   output logic                 rst_req_n
);
   if (NUM_FLAGS == 0 || NUM_FLAGS > DATA_W) begin : g_bad_n
      $error("NUM_FLAGS must be 1..DATA_W");
   end
   if (DATA_W < 2) begin : g_bad_dw
      $error("DATA_W must hold the two status bits");
   end
   if (ADDR_W < 2) begin : g_bad_aw
      $error("ADDR_W must reach three registers");
   end
   if (WDOG_IDX >= NUM_FLAGS) begin : g_bad_wd
      $error("WDOG_IDX outside the flag range");
   end

   logic [NUM_FLAGS-1:0] flag_q;
   logic [NUM_FLAGS-1:0] clr_mask;
   ctrl_t                ctrl_q;

   fault_flag_bank #(.N(NUM_FLAGS)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (fault_evt),
      .clr_i  (clr_mask),
      .flag_o (flag_q)
   );

   fault_route #(
      .N        (NUM_FLAGS),
      .RST_MASK (RST_ROUTE),
      .WD_IDX   (WDOG_IDX)
   ) u_route (
      .flag_i        (flag_q),
      .force_irq_i   (ctrl_q.force_irq),
      .wdog_rst_en_i (ctrl_q.wdog_rst_en),
      .irq_n_o       (irq_n),
      .rst_req_n_o   (rst_req_n)
   );

   fault_regif #(
      .N      (NUM_FLAGS),
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) u_regif (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_i        (reg_wr),
      .addr_i      (reg_addr),
      .wdata_i     (reg_wdata),
      .flag_i      (flag_q),
      .irq_n_i     (irq_n),
      .rst_req_n_i (rst_req_n),
      .clr_o       (clr_mask),
      .ctrl_o      (ctrl_q),
      .rdata_o     (reg_rdata)
   );
endmodule

// File: rtl/fault_irq_agg_chk.sv
module fault_irq_agg_chk #(
   parameter int unsigned N      = 11,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 2,
   parameter int unsigned WD_IDX = 5,
   parameter logic [N-1:0] ROUTE = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N-1:0]      fault_evt,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              irq_n,
   input logic              rst_req_n,
   input logic [N-1:0]      flag_q,
   input logic              force_irq,
   input logic              wdog_rst_en
);
   logic         past_ok;
   logic [N-1:0] wr_clear;
   logic [N-1:0] wd_only;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   assign wr_clear = (reg_wr && reg_addr == '0) ? reg_wdata[N-1:0] : '0;
   assign wd_only  = N'(1) << WD_IDX;

   assert_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> ((($past(flag_q) & ~$past(wr_clear)) & ~flag_q) == '0));

   assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (|fault_evt) |=> ((flag_q & $past(fault_evt)) == $past(fault_evt)));

   assert_irq_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((|flag_q) || force_irq) |-> !irq_n);

   assert_irq_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q == '0 && !force_irq) |-> irq_n);

   assert_rst_route_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (|(flag_q & ROUTE)) |-> !rst_req_n);

   assert_wdog_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q == wd_only && !wdog_rst_en && !ROUTE[WD_IDX]) |-> rst_req_n);

   assert_irq_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((flag_q & (ROUTE | wd_only)) == '0) |-> rst_req_n);

   assert_status_mirror_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(2)) |-> (reg_rdata[1:0] == {rst_req_n, irq_n}));
endmodule

bind fault_irq_agg fault_irq_agg_chk #(
   .N      (NUM_FLAGS),
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W),
   .WD_IDX (WDOG_IDX),
   .ROUTE  (RST_ROUTE)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .fault_evt   (fault_evt),
   .reg_wr      (reg_wr),
   .reg_addr    (reg_addr),
   .reg_wdata   (reg_wdata),
   .reg_rdata   (reg_rdata),
   .irq_n       (irq_n),
   .rst_req_n   (rst_req_n),
   .flag_q      (flag_q),
   .force_irq   (ctrl_q.force_irq),
   .wdog_rst_en (ctrl_q.wdog_rst_en)
);

// File: tb/fault_irq_agg_test.sv
`timescale 1ns/1ps
module fault_irq_agg_test;
   localparam int unsigned N  = 11;
   localparam int unsigned DW = 16;
   localparam int unsigned AW = 2;
   localparam logic [N-1:0] ROUTE = 11'b000_0001_1111;
   localparam int unsigned WD = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  fault_evt = '0;
   logic          reg_wr = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          irq_n, rst_req_n;

   int n_chk = 0;
   int n_bad = 0;
   logic [N-1:0] m_flags = '0;
   logic [1:0]   m_ctrl  = '0;

   always #5 clk = ~clk;

   fault_irq_agg uut (
      .clk(clk), .rst_n(rst_n), .fault_evt(fault_evt), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_n(irq_n), .rst_req_n(rst_req_n)
   );

   function automatic logic exp_irq(logic [N-1:0] f, logic [1:0] c);
      return ~((|f) | c[0]);
   endfunction

   function automatic logic exp_rst(logic [N-1:0] f, logic [1:0] c);
      logic [N-1:0] m;
      m = ROUTE;
      m[WD] = m[WD] | c[1];
      return ~(|(f & m));
   endfunction

   function automatic logic [DW-1:0] exp_read(logic [AW-1:0] a, logic [N-1:0] f, logic [1:0] c);
      logic [DW-1:0] r;
      r = '0;
      case (a)
         2'd0: r[N-1:0] = f;
         2'd1: r[1:0] = c;
         2'd2: r[1:0] = {exp_rst(f, c), exp_irq(f, c)};
         default: r = '0;
      endcase
      return r;
   endfunction

   task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   // One cycle: drive at the falling edge, check present state, let the edge update the model.
   task automatic step(string tag, logic [N-1:0] ev, logic wr, logic [AW-1:0] a, logic [DW-1:0] wd);
      @(negedge clk);
      fault_evt = ev; reg_wr = wr; reg_addr = a; reg_wdata = wd;
      #1;
      check({tag, " rdata"}, reg_rdata, exp_read(a, m_flags, m_ctrl));
      check({tag, " irq_n"}, DW'(irq_n), DW'(exp_irq(m_flags, m_ctrl)));
      check({tag, " rst_req_n"}, DW'(rst_req_n), DW'(exp_rst(m_flags, m_ctrl)));
      @(posedge clk);
      m_flags = (m_flags & ~((wr && a == 2'd0) ? wd[N-1:0] : '0)) | ev;
      if (wr && a == 2'd1) m_ctrl = wd[1:0];
   endtask

   task automatic idle(string tag, logic [AW-1:0] a);
      step(tag, '0, 1'b0, a, '0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      // R10 reset state: all reads and both pins
      idle("R10 reset flags", 2'd0);
      idle("R10 reset ctrl", 2'd1);
      idle("R10 reset status", 2'd2);
      idle("R10 addr3 zero", 2'd3);
      // R1 set and hold, interrupt-only source: R7
      step("R1 set osc", N'(1) << 6, 1'b0, 2'd0, '0);
      idle("R1 hold", 2'd0);
      idle("R7 osc no reset", 2'd2);
      // R2 write zero leaves flag, write one clears
      step("R2 write zero", '0, 1'b1, 2'd0, 16'h0000);
      idle("R2 after zero", 2'd0);
      step("R2 write one", '0, 1'b1, 2'd0, 16'h0040);
      idle("R2 cleared", 2'd0);
      // R5 thermal routes to reset
      step("R5 thermal", N'(1) << 2, 1'b0, 2'd0, '0);
      idle("R5 reset low", 2'd2);
      // R3 clear and set collide
      step("R3 collide", N'(1) << 2, 1'b1, 2'd0, 16'hFFFF);
      idle("R3 kept", 2'd0);
      step("R2 clear all", '0, 1'b1, 2'd0, 16'hFFFF);
      // R6 watchdog without then with enable
      step("R6 wdog set", N'(1) << WD, 1'b0, 2'd0, '0);
      idle("R6 no reset", 2'd2);
      step("R6 enable", '0, 1'b1, 2'd1, 16'h0002);
      idle("R6 reset low", 2'd2);
      step("R6 disable", '0, 1'b1, 2'd1, 16'h0000);
      step("R2 clear wdog", '0, 1'b1, 2'd0, 16'h0020);
      // R8 force and release
      step("R8 force on", '0, 1'b1, 2'd1, 16'h0001);
      idle("R8 forced", 2'd2);
      step("R8 force off", '0, 1'b1, 2'd1, 16'h0000);
      idle("R8 released", 2'd2);
      // R9 status is read-only
      step("R9 write status", '0, 1'b1, 2'd2, 16'hFFFF);
      idle("R9 flags untouched", 2'd0);
      idle("R9 ctrl untouched", 2'd1);
      // R10 unused bits and addr 3 after writes
      step("R10 write addr3", '0, 1'b1, 2'd3, 16'hFFFF);
      idle("R10 addr3 still zero", 2'd3);
      // R4 R5 R6 R7 random mix
      for (int k = 0; k < 600; k++) begin
         logic [N-1:0]  ev;
         logic          wr;
         logic [AW-1:0] a;
         logic [DW-1:0] wd;
         ev = N'($urandom & $urandom & $urandom);
         wr = ($urandom % 3) == 0;
         a  = AW'($urandom);
         wd = DW'($urandom);
         step("R4 random", ev, wr, a, wd);
      end
      idle("R1 final", 2'd0);
      summary();
   end
endmodule